// File: doc/BRIEF.md
# Chainable Interval Timer Channel

This block is one general-purpose timer channel. A counter runs down from a load value to zero, or up from zero to the load value. An 8-bit prescaler sits in front of the counter and sets how often it steps. The channel runs in one of two modes: one-shot stops after the first timeout, and periodic reloads and keeps running.

Software programs the channel through a small synchronous register port with a write strobe, a write address and write data. Reads are combinational from a separate read address.

- **Load timing.** New load and prescale values take effect on the cycle after the write. In count-down mode, software can instead hold them pending until the next timeout.
- **Snapshot.** In periodic mode, the channel can capture the count and the prescaler value at each timeout.
- **Chaining.** Each timeout produces a one-cycle pulse that can start the next channel in a daisy chain. A channel set to wait for a trigger does not count until that pulse arrives.
- **Match.** A match comparator sets a sticky status bit. The match interrupt enable gates the match strobes toward the DMA and ADC engines.

Top module: `chain_timer`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `timeout_pulse`, `dma_match_trig` and `adc_match_trig` are low. Register addresses are: 0 CFG, 1 LOAD, 2 PRESCALE, 3 MATCH, 4 STATUS, 5 COUNT, 6 COUNT snapshot, 7 PRESCALE snapshot. CFG bits are: 0 enable, 1 periodic (0 = one-shot), 2 count-up, 3 deferred load, 4 snapshot, 5 wait-for-trigger, 6 match interrupt enable, 7 timeout interrupt enable, 8 DMA match enable, 9 ADC match enable.
- R2: The mode is running, count-down, deferred load bit 0. A write to LOAD or PRESCALE is followed one clock edge later by COUNT equal to the new load value, with the prescaler restarted from the new prescale value.
- R3: The mode is count-down with deferred load set. A LOAD write leaves the count sequence untouched. The counter reloads from the new value at the next timeout.
- R4: In count-up mode the deferred load bit has no effect. A new LOAD value becomes the wrap limit one edge after the write.
- R5: Writes to LOAD and PRESCALE while disabled do not change COUNT. Setting enable loads COUNT (and the prescaler) from them on the next edge.
- R6: While running, the counter steps once every PRESCALE+1 clock cycles.
- R7: At timeout, periodic mode reloads the counter. A timeout happens at count 0 when counting down, and at the load value when counting up. One-shot mode instead clears CFG bit 0 and holds the count.
- R8: `timeout_pulse` is high for exactly the one cycle that precedes the timeout edge.
- R9: With wait-for-trigger set, an enabled channel holds its loaded count until a `chain_trig_in` pulse. The counter steps on the second edge after the pulse is sampled.
- R10: In periodic mode with snapshot set, each timeout copies the count into the count snapshot and the prescaler value into the prescale snapshot. Without snapshot, both registers keep their value.
- R11: A counter step taken at the MATCH value sets STATUS bit 1. If the match interrupt enable is set, `irq` rises.
- R12: `dma_match_trig` and `adc_match_trig` pulse during a matching step only when the match interrupt enable and their own enable are both set.
- R13: STATUS bits are sticky and are cleared by writing 1. `irq` is the OR of each status bit ANDed with its interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| chain_trig_in | input | 1 | Start trigger from the previous channel |
| timeout_pulse | output | 1 | One-cycle timeout strobe, chain output |
| irq | output | 1 | Interrupt request |
| dma_match_trig | output | 1 | Match strobe toward the DMA engine |
| adc_match_trig | output | 1 | Match strobe toward the ADC engine |

## Verification
The hardest case to reach from the ports is a deferred load. The new value has to be written mid-period and must stay invisible until the counter wraps. The bench writes LOAD two counts before zero and checks that the count keeps decrementing. It then waits for the timeout strobe and checks that the reload uses the new value. The trigger gating needs both match enable states with the DMA and ADC enables held on. The bench stops on the exact cycle the counter sits at the match value and samples the strobes in that cycle.

// File: rtl/chain_timer_pkg.sv
// Package: shared register addresses and the control-word layout of the
// chainable timer channel. Assumes a 3-bit register address space.
package chain_timer_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int CFG_W  = 10;

    localparam logic [ADDR_W-1:0] ADR_CFG   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_LOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_PSC   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_MATCH = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CNT   = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_SNAP  = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_PSNAP = 3'd7;

    // Control word; enable is bit 0, adc_en is bit 9.
    typedef struct packed {
        logic adc_en;
        logic dma_en;
        logic to_ie;
        logic match_ie;
        logic wait_trig;
        logic snap_en;
        logic defer_ld;
        logic count_up;
        logic periodic;
        logic enable;
    } cfg_t;

endpackage

// File: rtl/tmr_regs.sv
// Module: tmr_regs
// Holds the software-written control word and the pending load, prescale
// and match values. Emits a one-cycle pulse after any LOAD/PRESCALE write
// so the counter core can apply it on the following edge. Clears the enable
// bit when a one-shot timeout occurs. Assumes CNT_W and PSC_W <= DATA_W.
module tmr_regs
    import chain_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              to_evt,
    output cfg_t              cfg,
    output logic [CNT_W-1:0]  load_val,
    output logic [PSC_W-1:0]  psc_val,
    output logic [CNT_W-1:0]  match_val,
    output logic              ld_wr
);

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    // Register writes, apply pulse and one-shot self-clear of enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg       <= '0;
            load_val  <= '0;
            psc_val   <= '0;
            match_val <= '0;
            ld_wr     <= 1'b0;
        end else begin
            ld_wr <= wr_en && (wr_addr == ADR_LOAD || wr_addr == ADR_PSC);
            if (to_evt && !cfg.periodic)
                cfg.enable <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    ADR_CFG:   cfg       <= cfg_t'(wr_data[CFG_W-1:0]);
                    ADR_LOAD:  load_val  <= wr_data[CNT_W-1:0];
                    ADR_PSC:   psc_val   <= wr_data[PSC_W-1:0];
                    ADR_MATCH: match_val <= wr_data[CNT_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    // R7: a one-shot timeout leaves the channel disabled
    assert_oneshot_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (to_evt && !cfg.periodic && !(wr_en && wr_addr == ADR_CFG)) |=> !cfg.enable);

endmodule

// File: rtl/tmr_core.sv
// Module: tmr_core
// Prescaler and counter of one channel. Handles start-on-enable,
// wait-for-chain-trigger, immediate or deferred application of load values,
// periodic reload, one-shot hold and the timeout snapshot. An immediate
// apply replaces the count step of that cycle. Assumes cfg is registered.
module tmr_core
    import chain_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] load_val,
    input  logic [PSC_W-1:0] psc_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic             ld_wr,
    input  logic             trig_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] snap_cnt,
    output logic [PSC_W-1:0] snap_psc,
    output logic             to_evt,
    output logic             match_evt
);

    logic             en_q;
    logic             run;
    logic [CNT_W-1:0] load_live;
    logic [PSC_W-1:0] psc_live;
    logic [PSC_W-1:0] psc_cnt;
    logic             start;
    logic             imm_apply;
    logic             active;
    logic             tick;
    logic             at_end;
    logic             unused_cfg;

    assign unused_cfg = ^cfg;

    // Decode of this cycle's counting conditions.
    always_comb begin
        start     = cfg.enable && !en_q;
        imm_apply = ld_wr && !(cfg.defer_ld && !cfg.count_up);
        active    = cfg.enable && en_q && run && !imm_apply;
        tick      = (psc_cnt == '0);
        at_end    = cfg.count_up ? (cnt == load_live) : (cnt == '0);
        to_evt    = active && tick && at_end;
        match_evt = active && tick && (cnt == match_val);
    end

    // Counter, prescaler, run state and snapshot update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            run       <= 1'b0;
            cnt       <= '0;
            load_live <= '0;
            psc_live  <= '0;
            psc_cnt   <= '0;
            snap_cnt  <= '0;
            snap_psc  <= '0;
        end else begin
            en_q <= cfg.enable;
            if (!cfg.enable) begin
                run <= 1'b0;
            end else if (start) begin
                cnt       <= cfg.count_up ? '0 : load_val;
                load_live <= load_val;
                psc_live  <= psc_val;
                psc_cnt   <= psc_val;
                run       <= !cfg.wait_trig;
            end else begin
                if (!run && trig_in)
                    run <= 1'b1;
                if (imm_apply) begin
                    load_live <= load_val;
                    psc_live  <= psc_val;
                    psc_cnt   <= psc_val;
                    if (!cfg.count_up)
                        cnt <= load_val;
                end else if (run) begin
                    if (!tick) begin
                        psc_cnt <= psc_cnt - 1'b1;
                    end else if (at_end) begin
                        load_live <= load_val;
                        psc_live  <= psc_val;
                        psc_cnt   <= psc_val;
                        if (cfg.periodic)
                            cnt <= cfg.count_up ? '0 : load_val;
                        if (cfg.periodic && cfg.snap_en) begin
                            snap_cnt <= cnt;
                            snap_psc <= psc_cnt;
                        end
                    end else begin
                        psc_cnt <= psc_live;
                        cnt     <= cfg.count_up ? cnt + 1'b1 : cnt - 1'b1;
                    end
                end
            end
        end
    end

    // R2: an immediate count-down apply lands on the following edge
    assert_imm_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_apply && cfg.enable && en_q && !cfg.count_up) |=> (cnt == $past(load_val)));

    // R6: no count step between prescaler ticks
    assert_psc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(cnt));

    // R6: prescaler never exceeds its live reload value
    assert_psc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        psc_cnt <= psc_live);

    // R9: a waiting channel keeps its count
    assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.enable && en_q && !run && !imm_apply) |=> $stable(cnt));

endmodule

// File: rtl/tmr_events.sv
// Module: tmr_events
// Sticky write-1-to-clear status for timeout and match, the interrupt
// OR and the gated DMA/ADC match strobes. Assumes event inputs are
// single-cycle strobes from the counter core.
module tmr_events
    import chain_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cfg_t       cfg,
    input  logic       to_evt,
    input  logic       match_evt,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    output logic [1:0] sts,
    output logic       irq,
    output logic       dma_trig,
    output logic       adc_trig
);

    logic unused_cfg;
    assign unused_cfg = ^cfg;

    // Sticky status; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts[0] <= (sts[0] && !(clr_wr && clr_bits[0])) || to_evt;
            sts[1] <= (sts[1] && !(clr_wr && clr_bits[1])) || match_evt;
        end
    end

    // Interrupt OR and enable-gated match strobes.
    always_comb begin
        irq      = (sts[0] && cfg.to_ie) || (sts[1] && cfg.match_ie);
        dma_trig = match_evt && cfg.match_ie && cfg.dma_en;
        adc_trig = match_evt && cfg.match_ie && cfg.adc_en;
    end

    // R13: match status is held until cleared by a 1
    assert_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[1] && !(clr_wr && clr_bits[1])) |=> sts[1]);

    // R12: any match strobe is accompanied by a real match event
    assert_trig_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_trig || adc_trig) |=> sts[1]);

endmodule

// File: rtl/chain_timer.sv
// Module: chain_timer (top)
// One chainable timer channel: register block, counter core and event
// logic, plus the combinational read mux. Assumes a single clock domain
// and a synchronous register port.
module chain_timer
    import chain_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        chain_trig_in,
    output logic        timeout_pulse,
    output logic        irq,
    output logic        dma_match_trig,
    output logic        adc_match_trig
);

    cfg_t             cfg;
    logic [CNT_W-1:0] load_val;
    logic [PSC_W-1:0] psc_val;
    logic [CNT_W-1:0] match_val;
    logic             ld_wr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] snap_cnt;
    logic [PSC_W-1:0] snap_psc;
    logic             to_evt;
    logic             match_evt;
    logic [1:0]       sts;

    tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .to_evt(to_evt), .cfg(cfg), .load_val(load_val),
        .psc_val(psc_val), .match_val(match_val), .ld_wr(ld_wr)
    );

    tmr_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .load_val(load_val),
        .psc_val(psc_val), .match_val(match_val), .ld_wr(ld_wr),
        .trig_in(chain_trig_in), .cnt(cnt), .snap_cnt(snap_cnt),
        .snap_psc(snap_psc), .to_evt(to_evt), .match_evt(match_evt)
    );

    tmr_events u_events (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .to_evt(to_evt),
        .match_evt(match_evt), .clr_wr(wr_en && wr_addr == ADR_STAT),
        .clr_bits(wr_data[1:0]), .sts(sts), .irq(irq),
        .dma_trig(dma_match_trig), .adc_trig(adc_match_trig)
    );

    assign timeout_pulse = to_evt;

    // Combinational register readback, zero-extended.
    always_comb begin
        case (rd_addr)
            ADR_CFG:   rd_data = {{(DATA_W-CFG_W){1'b0}}, cfg};
            ADR_LOAD:  rd_data = {{(DATA_W-CNT_W){1'b0}}, load_val};
            ADR_PSC:   rd_data = {{(DATA_W-PSC_W){1'b0}}, psc_val};
            ADR_MATCH: rd_data = {{(DATA_W-CNT_W){1'b0}}, match_val};
            ADR_STAT:  rd_data = {30'b0, sts};
            ADR_CNT:   rd_data = {{(DATA_W-CNT_W){1'b0}}, cnt};
            ADR_SNAP:  rd_data = {{(DATA_W-CNT_W){1'b0}}, snap_cnt};
            default:   rd_data = {{(DATA_W-PSC_W){1'b0}}, snap_psc};
        endcase
    end

    // R8: the timeout strobe never coincides with a disabled channel
    assert_pulse_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> cfg.enable);

endmodule

// File: tb/chain_timer_tb.sv
module chain_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        chain_trig_in;
    logic        timeout_pulse;
    logic        irq;
    logic        dma_match_trig;
    logic        adc_match_trig;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    chain_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .chain_trig_in(chain_trig_in), .timeout_pulse(timeout_pulse),
        .irq(irq), .dma_match_trig(dma_match_trig),
        .adc_match_trig(adc_match_trig)
    );

    localparam logic [2:0] A_CFG = 0, A_LOAD = 1, A_PSC = 2, A_MATCH = 3,
                           A_STAT = 4, A_CNT = 5, A_SNAP = 6, A_PSNAP = 7;

    // {load, prescale, cycles after enable write, expected count}
    localparam logic [31:0] VEC [7] = '{
        {8'd10, 8'd0, 8'd1,  8'd10},
        {8'd10, 8'd0, 8'd5,  8'd6},
        {8'd10, 8'd0, 8'd12, 8'd10},
        {8'd5,  8'd2, 8'd10, 8'd2},
        {8'd5,  8'd2, 8'd20, 8'd5},
        {8'd3,  8'd1, 8'd7,  8'd0},
        {8'd7,  8'd3, 8'd13, 8'd4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Call at a negedge; returns at the negedge after the capture edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_timeout(input string req);
        logic seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (timeout_pulse) begin
                seen = 1'b1;
                break;
            end
        end
        check(req, {31'b0, seen}, 32'd1);
    endtask

    task automatic wait_count(input logic [31:0] v);
        logic [31:0] c;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            rd(A_CNT, c);
            if (c == v) break;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = A_CNT; chain_trig_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CFG, v);  check("R1 cfg", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_CNT, v);  check("R1 count", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 strobes", {29'b0, timeout_pulse, dma_match_trig, adc_match_trig}, 0);

        // R6, R7: table of prescaled periodic count-down runs
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            wr(A_CFG, 0);
            wr(A_LOAD, {24'b0, VEC[i][31:24]});
            wr(A_PSC, {24'b0, VEC[i][23:16]});
            wr(A_CFG, 32'h3);
            repeat (VEC[i][15:8]) @(negedge clk);
            rd(A_CNT, v);
            check($sformatf("R6 R7 vector %0d", i), v, {24'b0, VEC[i][7:0]});
        end

        // R2: immediate load while counting down
        wr(A_CFG, 0); wr(A_LOAD, 100); wr(A_PSC, 0); wr(A_CFG, 32'h3);
        repeat (3) @(negedge clk);
        wr(A_LOAD, 50);
        @(negedge clk);
        rd(A_CNT, v); check("R2 immediate load", v, 50);
        @(negedge clk);
        rd(A_CNT, v); check("R2 counts on", v, 49);

        // R3, R8: deferred load applies at timeout
        wr(A_CFG, 0); wr(A_LOAD, 4); wr(A_PSC, 0); wr(A_CFG, 32'hB);
        @(negedge clk);
        wr(A_LOAD, 9);
        @(negedge clk);
        rd(A_CNT, v); check("R3 deferred untouched", v, 2);
        @(negedge clk); @(negedge clk);
        check("R8 pulse before edge", {31'b0, timeout_pulse}, 1);
        @(negedge clk);
        check("R8 pulse one cycle", {31'b0, timeout_pulse}, 0);
        rd(A_CNT, v); check("R3 reload from pending", v, 9);

        // R4: count-up ignores deferral
        wr(A_CFG, 0); wr(A_STAT, 3); wr(A_LOAD, 20); wr(A_PSC, 0); wr(A_CFG, 32'hF);
        @(negedge clk);
        wr(A_LOAD, 3);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); check("R4 count at new limit", v, 3);
        check("R4 wraps at new limit", {31'b0, timeout_pulse}, 1);

        // R5: writes while disabled, then enable
        wr(A_CFG, 0);
        rd(A_CNT, c0);
        wr(A_LOAD, 33); wr(A_PSC, 0);
        rd(A_CNT, v); check("R5 disabled write no effect", v, c0);
        wr(A_CFG, 32'h1);
        @(negedge clk);
        rd(A_CNT, v); check("R5 load on enable", v, 33);

        // R7: one-shot stops and clears enable
        wait_timeout("R7 one-shot timeout");
        @(negedge clk);
        rd(A_CFG, v); check("R7 enable cleared", v & 1, 0);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); check("R7 one-shot holds", v, 0);

        // R9: wait for chain trigger
        wr(A_CFG, 0); wr(A_LOAD, 10); wr(A_PSC, 0); wr(A_CFG, 32'h23);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); check("R9 held before trigger", v, 10);
        chain_trig_in = 1'b1;
        @(negedge clk);
        chain_trig_in = 1'b0;
        rd(A_CNT, v); check("R9 trigger edge", v, 10);
        @(negedge clk);
        rd(A_CNT, v); check("R9 counting after trigger", v, 9);

        // R10: snapshot in periodic count-up
        wr(A_CFG, 0); wr(A_LOAD, 2); wr(A_PSC, 1); wr(A_CFG, 32'h17);
        wait_timeout("R10 timeout seen");
        @(negedge clk);
        rd(A_SNAP, v);  check("R10 count snapshot", v, 2);
        rd(A_PSNAP, v); check("R10 prescale snapshot", v, 0);
        wr(A_CFG, 0); wr(A_LOAD, 5); wr(A_PSC, 0); wr(A_CFG, 32'h7);
        wait_timeout("R10 second timeout");
        @(negedge clk);
        rd(A_SNAP, v);  check("R10 no snapshot when off", v, 2);

        // R11, R12, R13: match with interrupt enable clear
        wr(A_CFG, 0); wr(A_STAT, 3); wr(A_MATCH, 3); wr(A_LOAD, 6); wr(A_PSC, 0);
        wr(A_CFG, 32'h303);
        wait_count(3);
        check("R12 strobes gated off", {30'b0, dma_match_trig, adc_match_trig}, 0);
        @(negedge clk);
        rd(A_STAT, v); check("R11 match status", v & 2, 2);
        check("R13 irq masked", {31'b0, irq}, 0);
        wr(A_CFG, 0); wr(A_STAT, 3);
        rd(A_STAT, v); check("R13 write-one clear", v, 0);

        // R11, R12, R13: match with interrupt enable set
        wr(A_CFG, 32'h343);
        wait_count(3);
        check("R12 strobes pass", {30'b0, dma_match_trig, adc_match_trig}, 3);
        @(negedge clk);
        check("R11 irq on match", {31'b0, irq}, 1);
        wait_timeout("R13 timeout seen");
        @(negedge clk);
        wr(A_CFG, 32'h040);
        rd(A_STAT, v); check("R13 both sticky", v, 3);
        wr(A_STAT, 2);
        rd(A_STAT, v); check("R13 partial clear", v, 1);
        check("R13 irq after clear", {31'b0, irq}, 0);
        wr(A_CFG, 32'h080);
        check("R13 timeout enable", {31'b0, irq}, 1);

        finish_run();
    end

endmodule